// File: doc/BRIEF.md
# Up/Down Counter Timer with Double-Buffered PWM Channels

This block is a free-running counter of parameter width that counts up or down and carries a small number of channels. Each channel either captures the count on an edge of its input or compares the count and drives a PWM output. A compare hit or a capture sets a sticky per-channel flag, and the flag can be routed to an interrupt line. Software reaches the block through a flat register port. The port has one write strobe with address and data, and a combinational read selected by a separate read address.

The period and compare values are written into holding registers. In the immediate mode, and whenever the counter is stopped, a written value reaches the live register on the same edge as the write. In the buffered mode, while the counter runs, the live registers take the held values only on the edge at which the counter starts a new cycle. A change made mid-cycle therefore cannot cut a pulse short or drop one.

Top module: `updn_pwm_timer`

## Requirements
- R1: Running in up mode (control bit 1 = 0), the count rises by one per clock. When the count is at or above the live period, it returns to zero on the next edge, and that edge starts a new cycle.
- R2: Running in down mode (control bit 1 = 1), the count falls by one per clock. From zero it reloads with the live period value in force after that same edge, and that edge starts a new cycle.
- R3: With the run bit (control bit 0) clear, the count holds its value.
- R4: With the buffer bit (control bit 2) clear, or with the counter stopped, a write to the period (address 1) or a channel compare register (address 2 + channel) is visible in the live value on the next read.
- R5: With the buffer bit set and the counter running, live period and compare values change only on a cycle-start edge, and then take the last written values.
- R6: A compare-mode channel in up mode with compare value C below the period outputs high while count < C and low otherwise. The channel's polarity bit (control bit 7 + channel) inverts this.
- R7: In down mode, the same channel outputs high while period − count < C, so the high time is C counts at the start of each cycle, as in up mode.
- R8: When C is greater than or equal to the live period, the output stays at 1 XOR polarity for the whole cycle. When C is 0 and below the period, it stays at polarity.
- R9: In compare mode, while running, the count equal to the live compare value sets the channel flag on the next edge.
- R10: The capture input passes through two synchronizer flops and an edge detector. The channel mode bit (control bit 3 + channel) = 1 selects capture. The edge bit (control bit 5 + channel) selects the edge: 0 for rising, 1 for falling. On the selected edge the count is latched and the flag is set on the third clock edge after the input changes. The other edge does nothing.
- R11: Flags (status address 4, bit = channel) are sticky. Writing 1 to a bit clears it, and writing 0 leaves it. A set in the same cycle wins over the clear.
- R12: The interrupt line of a channel is its flag AND its enable bit (control bit 9 + channel).
- R13: A capture-mode channel drives its PWM output low, and a read of its channel address returns the captured count, not the compare value.
- R14: The reads return the following. Address 0 gives the control bits 10..0. Address 1 gives the live period. Address 4 gives the flags. Address 5 gives the count. Any other address gives zero. Reset leaves control at 0, period at all ones, compare values, captures, flags and count at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data for rd_addr |
| cap_in | input | 2 | Asynchronous capture inputs, one per channel |
| pwm_out | output | 2 | PWM outputs, one per channel |
| irq | output | 2 | Interrupt lines, one per channel |

## Verification
The bench polls the count to a known position and writes the period and compare values mid-cycle in buffered mode. A design that loaded them at once would show the new period before the wrap. A design that loaded them late would still show the old period after the wrap. The bench runs down mode with both a partial compare and a compare above the period, which exposes an unmirrored duty cycle and a down reload that uses the stale period. In capture mode the bench stops the counter, reads the held count and then drives the unselected edge followed by the selected one. A wrong edge decode or a wrong synchronizer depth shows up as a captured value or flag that differs from the held count. Clearing flags with 0 and with 1 separates write-1-to-clear from plain writes.

// File: rtl/udt_pkg.sv
package udt_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // control word: global bits, then four per-channel fields of NCH bits
    localparam int CTL_RUN     = 0;
    localparam int CTL_DIR     = 1;
    localparam int CTL_DBUF    = 2;
    localparam int CTL_CH_BASE = 3;

    localparam int FLD_MODE = 0;
    localparam int FLD_EDGE = 1;
    localparam int FLD_POL  = 2;
    localparam int FLD_IE   = 3;

    localparam int ADDR_CTRL    = 0;
    localparam int ADDR_PERIOD  = 1;
    localparam int ADDR_CH_BASE = 2;

    function automatic int ctl_pos(int field, int ch, int nch);
        return CTL_CH_BASE + field * nch + ch;
    endfunction

    function automatic int ctl_width(int nch);
        return CTL_CH_BASE + 4 * nch;
    endfunction

endpackage

// File: rtl/udt_capsync.sv
module udt_capsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rose,
    output logic fell
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[STAGES-2:0], async_in};
        s_d.prev = s_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rose = s_q.sh[STAGES-1] & ~s_q.prev;
    assign fell = ~s_q.sh[STAGES-1] & s_q.prev;

    // R10: an edge is a single-cycle event
    assert_edge_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rose |=> !rose) else $error("rose held two cycles");

endmodule

// File: rtl/udt_counter.sv
module udt_counter
    import udt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  dir_e          dir,
    input  logic          load,
    input  logic [CW-1:0] per_buf_nxt,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] per_act,
    output logic          wrap
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] per;
    } cstate_t;

    cstate_t s_d, s_q;

    assign wrap = run && ((dir == DIR_DOWN) ? (s_q.cnt == '0) : (s_q.cnt >= s_q.per));

    always_comb begin
        s_d     = s_q;
        s_d.per = load ? per_buf_nxt : s_q.per;
        if (run) begin
            if (wrap) begin
                s_d.cnt = (dir == DIR_DOWN) ? s_d.per : '0;
            end else if (dir == DIR_DOWN) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.per <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt     = s_q.cnt;
    assign per_act = s_q.per;

    assert_up_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dir == DIR_UP && s_q.cnt < s_q.per) |=> (s_q.cnt == $past(s_q.cnt) + 1'b1))
        else $error("up step wrong");

    assert_up_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dir == DIR_UP && s_q.cnt >= s_q.per) |=> (s_q.cnt == '0))
        else $error("up wrap wrong");

    assert_down_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dir == DIR_DOWN && s_q.cnt == '0) |=> (s_q.cnt == s_q.per))
        else $error("down reload wrong");

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(s_q.cnt)) else $error("count moved while stopped");

endmodule

// File: rtl/udt_channel.sv
module udt_channel
    import udt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  dir_e          dir,
    input  logic          cap_mode,
    input  logic          edge_fall,
    input  logic          pol,
    input  logic          load,
    input  logic [CW-1:0] cmp_buf_nxt,
    input  logic [CW-1:0] cnt_q,
    input  logic [CW-1:0] per_q,
    input  logic          rose,
    input  logic          fell,
    input  logic          clr,
    output logic          pwm,
    output logic          flag,
    output logic [CW-1:0] cmp_act,
    output logic [CW-1:0] cap_val
);
    typedef struct packed {
        logic [CW-1:0] cmp;
        logic [CW-1:0] cap;
        logic          flag;
    } chstate_t;

    chstate_t s_d, s_q;
    logic     cap_evt, match, raw;

    assign cap_evt = cap_mode && (edge_fall ? fell : rose);
    assign match   = !cap_mode && run && (cnt_q == s_q.cmp);

    always_comb begin
        s_d     = s_q;
        s_d.cmp = load ? cmp_buf_nxt : s_q.cmp;
        if (cap_evt) s_d.cap = cnt_q;
        if (cap_evt || match) s_d.flag = 1'b1;
        else if (clr)         s_d.flag = 1'b0;
    end

    always_comb begin
        if (s_q.cmp >= per_q) begin
            raw = 1'b1;
        end else if (dir == DIR_DOWN) begin
            raw = ({1'b0, per_q} < ({1'b0, cnt_q} + {1'b0, s_q.cmp}));
        end else begin
            raw = (cnt_q < s_q.cmp);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pwm     = cap_mode ? 1'b0 : (raw ^ pol);
    assign flag    = s_q.flag;
    assign cmp_act = s_q.cmp;
    assign cap_val = s_q.cap;

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !clr) |=> s_q.flag) else $error("flag dropped");

    assert_match_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_mode && run && cnt_q == s_q.cmp) |=> s_q.flag) else $error("match lost");

    assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (s_q.cap == $past(cnt_q) && s_q.flag)) else $error("capture wrong");

endmodule

// File: rtl/updn_pwm_timer.sv
module updn_pwm_timer
    import udt_pkg::*;
#(
    parameter int CW          = 16,
    parameter int NCH         = 2,
    parameter int AW          = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [CW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [CW-1:0]  rd_data,
    input  logic [NCH-1:0] cap_in,
    output logic [NCH-1:0] pwm_out,
    output logic [NCH-1:0] irq
);
    localparam int CTLW     = ctl_width(NCH);
    localparam int ADDR_ST  = ADDR_CH_BASE + NCH;
    localparam int ADDR_CNT = ADDR_ST + 1;

    typedef struct packed {
        logic [CTLW-1:0]         ctrl;
        logic [CW-1:0]           per_buf;
        logic [NCH-1:0][CW-1:0]  cmp_buf;
    } regs_t;

    regs_t r_d, r_q;

    logic                   wr_ctrl, wr_per, wr_st;
    logic [NCH-1:0]         wr_cmp;
    logic                   run, dbuf, load, wrap;
    dir_e                   dir;
    logic [CW-1:0]          cnt, per_act;
    logic [NCH-1:0][CW-1:0] cmp_act, cap_val;
    logic [NCH-1:0]         flag, rose, fell, clr, cap_mode, ie;

    assign run  = r_q.ctrl[CTL_RUN];
    assign dir  = dir_e'(r_q.ctrl[CTL_DIR]);
    assign dbuf = r_q.ctrl[CTL_DBUF];
    assign load = !dbuf || !run || wrap;

    always_comb begin
        wr_ctrl = wr_en && (wr_addr == AW'(ADDR_CTRL));
        wr_per  = wr_en && (wr_addr == AW'(ADDR_PERIOD));
        wr_st   = wr_en && (wr_addr == AW'(ADDR_ST));
        r_d     = r_q;
        if (wr_ctrl) r_d.ctrl    = wr_data[CTLW-1:0];
        if (wr_per)  r_d.per_buf = wr_data;
        for (int i = 0; i < NCH; i++) begin
            wr_cmp[i] = wr_en && (wr_addr == AW'(ADDR_CH_BASE + i));
            if (wr_cmp[i]) r_d.cmp_buf[i] = wr_data;
        end
    end

    assign clr = wr_st ? wr_data[NCH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl    <= '0;
            r_q.per_buf <= '1;
            r_q.cmp_buf <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    udt_counter #(.CW(CW)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .dir         (dir),
        .load        (load),
        .per_buf_nxt (r_d.per_buf),
        .cnt         (cnt),
        .per_act     (per_act),
        .wrap        (wrap)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int P_MODE = ctl_pos(FLD_MODE, g, NCH);
        localparam int P_EDGE = ctl_pos(FLD_EDGE, g, NCH);
        localparam int P_POL  = ctl_pos(FLD_POL,  g, NCH);
        localparam int P_IE   = ctl_pos(FLD_IE,   g, NCH);

        assign cap_mode[g] = r_q.ctrl[P_MODE];
        assign ie[g]       = r_q.ctrl[P_IE];

        udt_capsync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (cap_in[g]),
            .rose     (rose[g]),
            .fell     (fell[g])
        );

        udt_channel #(.CW(CW)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .run         (run),
            .dir         (dir),
            .cap_mode    (r_q.ctrl[P_MODE]),
            .edge_fall   (r_q.ctrl[P_EDGE]),
            .pol         (r_q.ctrl[P_POL]),
            .load        (load),
            .cmp_buf_nxt (r_d.cmp_buf[g]),
            .cnt_q       (cnt),
            .per_q       (per_act),
            .rose        (rose[g]),
            .fell        (fell[g]),
            .clr         (clr[g]),
            .pwm         (pwm_out[g]),
            .flag        (flag[g]),
            .cmp_act     (cmp_act[g]),
            .cap_val     (cap_val[g])
        );
    end

    assign irq = flag & ie;

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(ADDR_CTRL))   rd_data[CTLW-1:0] = r_q.ctrl;
        if (rd_addr == AW'(ADDR_PERIOD)) rd_data = per_act;
        if (rd_addr == AW'(ADDR_ST))     rd_data[NCH-1:0] = flag;
        if (rd_addr == AW'(ADDR_CNT))    rd_data = cnt;
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == AW'(ADDR_CH_BASE + i))
                rd_data = cap_mode[i] ? cap_val[i] : cmp_act[i];
        end
    end

    assert_dbuf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbuf && run && !wrap) |=> $stable(per_act)) else $error("period moved mid-cycle");

    assert_direct_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_per && (!dbuf || !run)) |=> (per_act == $past(wr_data)))
        else $error("immediate period write lost");

endmodule

// File: tb/updn_pwm_timer_test.sv
module updn_pwm_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [1:0]  cap_in = '0;
    logic [1:0]  pwm_out;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updn_pwm_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in), .pwm_out(pwm_out), .irq(irq)
    );

    // ---------------- reference model ----------------
    logic [10:0] m_ctrl, n_ctrl;
    logic [15:0] m_cnt, m_per, m_pb, n_cnt, n_per, n_pb;
    logic [15:0] m_cb [2];
    logic [15:0] m_cm [2];
    logic [15:0] m_cap [2];
    logic [1:0]  m_fl, m_s1, m_s2, m_pv;
    logic        t_run, t_dn, t_wrap, t_ld, t_evt, t_match;

    initial begin
        m_ctrl = '0; m_cnt = '0; m_per = '1; m_pb = '1; m_fl = '0;
        m_s1 = '0; m_s2 = '0; m_pv = '0;
        for (int i = 0; i < 2; i++) begin m_cb[i] = '0; m_cm[i] = '0; m_cap[i] = '0; end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_cnt = '0; m_per = '1; m_pb = '1; m_fl = '0;
            m_s1 = '0; m_s2 = '0; m_pv = '0;
            for (int i = 0; i < 2; i++) begin m_cb[i] = '0; m_cm[i] = '0; m_cap[i] = '0; end
        end else begin
            t_run  = m_ctrl[0];
            t_dn   = m_ctrl[1];
            t_wrap = t_run && (t_dn ? (m_cnt == 0) : (m_cnt >= m_per));
            t_ld   = !m_ctrl[2] || !t_run || t_wrap;
            n_ctrl = (wr_en && wr_addr == 3'd0) ? wr_data[10:0] : m_ctrl;
            n_pb   = (wr_en && wr_addr == 3'd1) ? wr_data : m_pb;
            n_per  = t_ld ? n_pb : m_per;
            if (!t_run)      n_cnt = m_cnt;
            else if (t_wrap) n_cnt = t_dn ? n_per : 16'd0;
            else             n_cnt = t_dn ? m_cnt - 16'd1 : m_cnt + 16'd1;
            for (int i = 0; i < 2; i++) begin
                if (wr_en && wr_addr == 3'(2 + i)) m_cb[i] = wr_data;
                t_evt = m_ctrl[3+i] && (m_ctrl[5+i] ? (!m_s2[i] && m_pv[i]) : (m_s2[i] && !m_pv[i]));
                t_match = !m_ctrl[3+i] && t_run && (m_cnt == m_cm[i]);
                if (t_evt) m_cap[i] = m_cnt;
                if (t_evt || t_match) m_fl[i] = 1'b1;
                else if (wr_en && wr_addr == 3'd4 && wr_data[i]) m_fl[i] = 1'b0;
                if (t_ld) m_cm[i] = m_cb[i];
            end
            m_pv = m_s2; m_s2 = m_s1; m_s1 = cap_in;
            m_ctrl = n_ctrl; m_pb = n_pb; m_per = n_per; m_cnt = n_cnt;
        end
    end

    function automatic logic m_pwm(int i);
        logic raw;
        if (m_ctrl[3+i]) return 1'b0;
        if (m_cm[i] >= m_per)  raw = 1'b1;
        else if (m_ctrl[1])    raw = int'(m_per) < int'(m_cnt) + int'(m_cm[i]);
        else                   raw = m_cnt < m_cm[i];
        return raw ^ m_ctrl[7+i];
    endfunction

    function automatic logic [15:0] m_rd(logic [2:0] a);
        case (a)
            3'd0: return {5'd0, m_ctrl};
            3'd1: return m_per;
            3'd2: return m_ctrl[3] ? m_cap[0] : m_cm[0];
            3'd3: return m_ctrl[4] ? m_cap[1] : m_cm[1];
            3'd4: return {14'd0, m_fl};
            3'd5: return m_cnt;
            default: return 16'd0;
        endcase
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 2; i++) begin
                string tag;
                if (m_ctrl[3+i])            tag = "R13";
                else if (m_cm[i] >= m_per)  tag = "R8";
                else if (m_ctrl[1])         tag = "R7";
                else                        tag = "R6";
                chk(tag, 16'(pwm_out[i]), 16'(m_pwm(i)), "pwm");
            end
            chk("R12", 16'(irq), 16'(m_fl & {m_ctrl[10], m_ctrl[9]}), "irq");
            if (rd_addr == 3'd5)      chk(m_ctrl[1] ? "R2" : "R1", rd_data, m_rd(rd_addr), "count");
            else if (rd_addr == 3'd3) chk("R10", rd_data, m_rd(rd_addr), "ch1 read");
            else                      chk("R14", rd_data, m_rd(rd_addr), "read");
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rdchk(string tag, logic [2:0] a, logic [15:0] exp);
        rd_addr = a;
        @(negedge clk); #1;
        chk(tag, rd_data, exp, "directed read");
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] held, a, b;
        int guard;
        idle(3);
        rst_n = 1'b1;
        #1;
        // reset state
        rdchk("R14", 3'd0, 16'h0000);
        rdchk("R14", 3'd1, 16'hFFFF);
        rdchk("R14", 3'd5, 16'h0000);
        chk("R14", 16'(pwm_out), 16'h0, "reset pwm");

        // immediate writes while stopped, then run up with interrupts enabled
        wr(3'd1, 16'd9);
        rdchk("R4", 3'd1, 16'd9);
        wr(3'd2, 16'd4);
        wr(3'd3, 16'd12);
        rdchk("R4", 3'd2, 16'd4);
        wr(3'd0, 16'h0601);
        rdchk("R14", 3'd0, 16'h0601);
        rd_addr = 3'd5;
        idle(25);
        rdchk("R9", 3'd4, 16'h0001);
        chk("R12", 16'(irq), 16'h1, "irq after match");
        chk("R8", 16'(pwm_out[1]), 16'h1, "compare above period");

        // stop, then exercise write-1-to-clear
        wr(3'd0, 16'h0600);
        wr(3'd4, 16'h0000);
        rdchk("R11", 3'd4, 16'h0001);
        wr(3'd4, 16'h0001);
        rdchk("R11", 3'd4, 16'h0000);
        wr(3'd0, 16'h0700);
        chk("R8", 16'(pwm_out[1]), 16'h0, "inverted constant");

        // down counting
        wr(3'd0, 16'h0003);
        rd_addr = 3'd5;
        idle(25);
        wr(3'd0, 16'h0002);
        rdchk("R3", 3'd5, m_cnt);
        a = rd_data;
        idle(5);
        rdchk("R3", 3'd5, a);

        // double-buffered update mid-cycle
        wr(3'd0, 16'h0005);
        rd_addr = 3'd5;
        guard = 0;
        do begin
            @(negedge clk); #1;
            b = rd_data;
            guard++;
        end while (b != 16'd2 && guard < 50);
        chk("R1", b, 16'd2, "poll count");
        wr(3'd1, 16'd5);
        rdchk("R5", 3'd1, 16'd9);
        wr(3'd2, 16'd2);
        rdchk("R5", 3'd2, 16'd4);
        rd_addr = 3'd5;
        idle(12);
        rdchk("R5", 3'd1, 16'd5);
        rdchk("R5", 3'd2, 16'd2);

        // stopped with buffering on: immediate
        wr(3'd0, 16'h0004);
        wr(3'd1, 16'd7);
        rdchk("R4", 3'd1, 16'd7);

        // capture on channel 1, rising edge, while running
        wr(3'd0, 16'h0011);
        rd_addr = 3'd3;
        idle(3);
        cap_in[1] = 1'b1;
        idle(10);
        chk("R13", 16'(pwm_out[1]), 16'h0, "capture-mode pwm");
        cap_in[1] = 1'b0;
        idle(6);
        wr(3'd0, 16'h0010);
        idle(2);
        rdchk("R10", 3'd5, m_cnt);
        held = rd_data;
        rdchk("R10", 3'd3, m_cap[1]);
        a = rd_data;
        wr(3'd0, 16'h0050);
        wr(3'd4, 16'h0003);
        cap_in[1] = 1'b1;
        idle(6);
        rdchk("R10", 3'd3, a);
        rdchk("R10", 3'd4, 16'h0000);
        cap_in[1] = 1'b0;
        idle(6);
        rdchk("R10", 3'd3, held);
        rdchk("R10", 3'd4, 16'h0002);
        rdchk("R13", 3'd3, held);

        idle(2);
        finish_run();
    end

endmodule